// File: doc/BRIEF.md
# Buffered Output-Compare Channel

This block is one compare channel that sits beside a 16-bit timer/counter. It keeps an active compare value and flags an equality between that value and the running count. The flag latches and can raise an interrupt request. The active value is also driven out so that the counter can use it as its wrap point (TOP), which sets the period of a generated waveform. The counter and the waveform pin logic are not part of this block. They appear only as inputs: the count, a timer-clock enable, and strobes for the top and bottom extremes.

Software writes the compare value over an 8-bit bus, one byte at a time. A high-byte write is parked in a temporary latch. The following low-byte write commits all 16 bits in a single cycle. In the non-PWM modes the commit goes straight to the active register. In the two PWM modes it lands in a shadow register, and the shadow is copied to the active register only at the mode's update point. This prevents torn, odd-length pulses.

Top module: `oc_channel`

## Requirements
- R1: `match` is high in the same cycle whenever `cnt` equals `top_val`, with no register in between.
- R2: `flag` becomes 1 on the clock edge where `tick` and `match` are both high, so it is visible the cycle after the match. A match while `tick` is low leaves `flag` unchanged.
- R3: `irq` is high exactly when `flag` is 1 and `irq_en` is 1.
- R4: `flag` is cleared by `irq_ack`, or by a bus write of data bit0 = 1 to address 2'b10. Writing 0 to that bit has no effect. If a set condition (R2) occurs in the same cycle as a clear, the set wins.
- R5: A bus write to address 2'b01 only loads the 8-bit temporary latch and changes neither compare register. A write to address 2'b00 commits {latch, data} as one 16-bit value.
- R6: In mode 2'b00 (normal) and mode 2'b01 (clear-on-match), a commit appears on `top_val` on the next cycle.
- R7: In mode 2'b10 (single-slope PWM) and mode 2'b11 (dual-slope PWM), a commit goes to the shadow register, and `top_val` keeps its old value until the update point.
- R8: In mode 2'b10 the shadow is copied on a clock where `tick` and `at_top` are high. In mode 2'b11 it is copied on a clock where `tick` and `at_bottom` are high. The other extreme, or either extreme with `tick` low, copies nothing.
- R9: `top_val` changes only through a commit or a shadow copy. Counter activity alone never alters it.
- R10: When a low-byte commit and a counted match fall in the same cycle, the register takes the written value and `flag` is still set from the match.
- R11: After reset, `top_val` is 0, the shadow and latch are 0, and `flag` and `irq` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| tick | input | 1 | Timer clock enable |
| cnt | input | 16 | Current counter value |
| at_top | input | 1 | Counter is at its TOP value |
| at_bottom | input | 1 | Counter is at its BOTTOM value |
| mode | input | 2 | 00 normal, 01 clear-on-match, 10 single-slope PWM, 11 dual-slope PWM |
| irq_en | input | 1 | Interrupt enable |
| irq_ack | input | 1 | Interrupt serviced, clears the flag |
| wr_en | input | 1 | Bus write strobe |
| wr_addr | input | 2 | 00 low byte/commit, 01 high byte latch, 10 flag clear |
| wr_data | input | 8 | Bus write data |
| top_val | output | 16 | Active compare value, also the counter TOP |
| match | output | 1 | Count equals active compare value |
| flag | output | 1 | Sticky compare flag |
| irq | output | 1 | Interrupt request |

## Verification
The hardest case to reach is a bus commit and a counted match that land in the same clock. The bench first sets the count equal to the active value and clears the flag. It then raises `tick` in the very cycle that carries the low-byte write. That shows the new value taking the register while the flag still latches the old match. The PWM update points need similar care: each extreme is pulsed with and without `tick`, in both slope modes, so that only the chosen point moves a pending value.

// File: rtl/oc_pkg.sv
package oc_pkg;
  typedef enum logic [1:0] {
    OC_NORMAL = 2'b00,
    OC_CLRMAT = 2'b01,
    OC_PWM_SS = 2'b10,
    OC_PWM_DS = 2'b11
  } oc_mode_e;

  typedef enum logic [1:0] {
    OC_A_LO  = 2'b00,
    OC_A_HI  = 2'b01,
    OC_A_CLR = 2'b10,
    OC_A_RSV = 2'b11
  } oc_addr_e;
endpackage

// File: rtl/oc_rst_sync.sv
module oc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sh_q[STAGES-1];
endmodule

// File: rtl/oc_bus_port.sv
module oc_bus_port
  import oc_pkg::*;
#(
  parameter int BW = 8,
  localparam int DW = 2 * BW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [1:0]    wr_addr,
  input  logic [BW-1:0] wr_data,
  output logic          commit,
  output logic [DW-1:0] commit_val,
  output logic          flag_clr
);
  logic [BW-1:0] hi_q, hi_d;
  logic          hi_en;

  always_comb begin
    hi_en = wr_en && (wr_addr == OC_A_HI);
    hi_d  = hi_en ? wr_data : hi_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hi_q <= '0;
    else        hi_q <= hi_d;
  end

  assign commit     = wr_en && (wr_addr == OC_A_LO);
  assign commit_val = {hi_q, wr_data};
  assign flag_clr   = wr_en && (wr_addr == OC_A_CLR) && wr_data[0];
endmodule

// File: rtl/oc_value_regs.sv
module oc_value_regs
  import oc_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    mode,
  input  logic          tick,
  input  logic          at_top,
  input  logic          at_bottom,
  input  logic          commit,
  input  logic [DW-1:0] commit_val,
  output logic [DW-1:0] active_val
);
  logic [DW-1:0] act_q, act_d;
  logic [DW-1:0] shd_q, shd_d;
  logic          buffered, upd_pt, load;

  always_comb begin
    buffered = mode[1];
    upd_pt   = (mode == OC_PWM_DS) ? at_bottom : at_top;
    load     = buffered && tick && upd_pt;

    shd_d = commit ? commit_val : shd_q;

    act_d = act_q;
    if (!buffered && commit) act_d = commit_val;
    else if (load)           act_d = shd_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= '0;
      shd_q <= '0;
    end else begin
      act_q <= act_d;
      shd_q <= shd_d;
    end
  end

  assign active_val = act_q;
endmodule

// File: rtl/oc_match_flag.sv
module oc_match_flag #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] cnt,
  input  logic [DW-1:0] active_val,
  input  logic          tick,
  input  logic          ack,
  input  logic          sw_clr,
  input  logic          irq_en,
  output logic          match,
  output logic          flag,
  output logic          irq
);
  logic flg_q, flg_d;
  logic set_c, clr_c;

  always_comb begin
    match = (cnt == active_val);
    set_c = tick && match;
    clr_c = ack || sw_clr;
    flg_d = flg_q;
    if (set_c)      flg_d = 1'b1;
    else if (clr_c) flg_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flg_q <= 1'b0;
    else        flg_q <= flg_d;
  end

  assign flag = flg_q;
  assign irq  = flg_q && irq_en;
endmodule

// File: rtl/oc_channel.sv
module oc_channel
  import oc_pkg::*;
#(
  parameter int BW = 8,
  localparam int DW = 2 * BW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic [DW-1:0] cnt,
  input  logic          at_top,
  input  logic          at_bottom,
  input  logic [1:0]    mode,
  input  logic          irq_en,
  input  logic          irq_ack,
  input  logic          wr_en,
  input  logic [1:0]    wr_addr,
  input  logic [BW-1:0] wr_data,
  output logic [DW-1:0] top_val,
  output logic          match,
  output logic          flag,
  output logic          irq
);
  logic          rst_i_n;
  logic          commit, flag_clr;
  logic [DW-1:0] commit_val;

  oc_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_i_n)
  );

  oc_bus_port #(.BW(BW)) u_bus (
    .clk(clk), .rst_n(rst_i_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .commit(commit), .commit_val(commit_val),
    .flag_clr(flag_clr)
  );

  oc_value_regs #(.DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_i_n), .mode(mode), .tick(tick),
    .at_top(at_top), .at_bottom(at_bottom), .commit(commit),
    .commit_val(commit_val), .active_val(top_val)
  );

  oc_match_flag #(.DW(DW)) u_flag (
    .clk(clk), .rst_n(rst_i_n), .cnt(cnt), .active_val(top_val),
    .tick(tick), .ack(irq_ack), .sw_clr(flag_clr), .irq_en(irq_en),
    .match(match), .flag(flag), .irq(irq)
  );
endmodule

// File: rtl/oc_channel_chk.sv
module oc_channel_chk #(
  parameter int BW = 8,
  localparam int DW = 2 * BW
) (
  input logic          clk,
  input logic          rst_i_n,
  input logic          tick,
  input logic [DW-1:0] cnt,
  input logic          at_top,
  input logic          at_bottom,
  input logic [1:0]    mode,
  input logic          irq_en,
  input logic          irq_ack,
  input logic          wr_en,
  input logic [1:0]    wr_addr,
  input logic [BW-1:0] wr_data,
  input logic [DW-1:0] top_val,
  input logic          match,
  input logic          flag,
  input logic          irq
);
  // R2: a counted match latches the flag
  p_flag_set_r2: assert property (@(posedge clk) disable iff (!rst_i_n)
    (tick && match) |=> flag);

  // R2: no counted match means flag cannot rise
  p_no_spur_r2: assert property (@(posedge clk) disable iff (!rst_i_n)
    !(tick && match) |=> !$rose(flag));

  // R3: request only with a pending flag
  p_irq_gate_r3: assert property (@(posedge clk) disable iff (!rst_i_n)
    irq |-> (flag && irq_en));

  // R4: acknowledge without a new match clears
  p_ack_clr_r4: assert property (@(posedge clk) disable iff (!rst_i_n)
    (irq_ack && !(tick && match)) |=> !flag);

  // R6: direct modes commit the low byte on the next cycle
  p_direct_r6: assert property (@(posedge clk) disable iff (!rst_i_n)
    (!mode[1] && wr_en && wr_addr == 2'b00) |=> top_val[BW-1:0] == $past(wr_data));

  // R7 R9: without commit or update point the active value holds
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_i_n)
    (!(wr_en && wr_addr == 2'b00 && !mode[1]) &&
     !(mode[1] && tick && (at_top || at_bottom))) |=> $stable(top_val));
endmodule

bind oc_channel oc_channel_chk #(.BW(BW)) u_chk (
  .clk(clk), .rst_i_n(rst_i_n), .tick(tick), .cnt(cnt), .at_top(at_top),
  .at_bottom(at_bottom), .mode(mode), .irq_en(irq_en), .irq_ack(irq_ack),
  .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .top_val(top_val),
  .match(match), .flag(flag), .irq(irq)
);

// File: tb/tb_oc_channel.sv
module tb_oc_channel;
  logic        clk, rst_n, tick, at_top, at_bottom, irq_en, irq_ack, wr_en;
  logic [15:0] cnt;
  logic [1:0]  mode, wr_addr;
  logic [7:0]  wr_data;
  logic [15:0] top_val;
  logic        match, flag, irq;
  int total = 0, bad = 0;
  bit finished = 0;

  oc_channel dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cnt(cnt), .at_top(at_top),
    .at_bottom(at_bottom), .mode(mode), .irq_en(irq_en), .irq_ack(irq_ack),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .top_val(top_val), .match(match), .flag(flag), .irq(irq)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  // advance one clock; inputs change and outputs are read 2 ns after the edge
  task automatic step();
    @(posedge clk); #2;
  endtask

  task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    step();
    wr_en = 1'b0;
    #1;
  endtask

  task automatic t_reset();
    chk("R11 top", top_val, 16'h0);
    chk("R11 flag", flag, 1'b0);
    chk("R11 irq", irq, 1'b0);
    chk("R11 match", match, 1'b0);
  endtask

  task automatic t_direct();
    mode = 2'b00;
    bus_wr(2'b01, 8'h12);
    chk("R5 hi only", top_val, 16'h0);
    bus_wr(2'b00, 8'h34);
    chk("R6 commit", top_val, 16'h1234);
    cnt = 16'h1234; #1;
    chk("R1 match", match, 1'b1);
    cnt = 16'h1235; #1;
    chk("R1 nomatch", match, 1'b0);
    mode = 2'b01;
    bus_wr(2'b01, 8'h55);
    chk("R5 latch", top_val, 16'h1234);
    bus_wr(2'b00, 8'h66);
    chk("R6 clrmat", top_val, 16'h5566);
  endtask

  task automatic t_flag();
    mode = 2'b00;
    cnt = 16'h5566; #1;
    step();
    chk("R2 no tick", flag, 1'b0);
    tick = 1'b1; step(); tick = 1'b0; #1;
    chk("R2 set", flag, 1'b1);
    chk("R3 irq off", irq, 1'b0);
    irq_en = 1'b1; #1;
    chk("R3 irq on", irq, 1'b1);
    bus_wr(2'b10, 8'h00);
    chk("R4 write0", flag, 1'b1);
    bus_wr(2'b10, 8'h01);
    chk("R4 sw clr", flag, 1'b0);
    chk("R3 irq drop", irq, 1'b0);
    tick = 1'b1; step(); tick = 1'b0; #1;
    irq_ack = 1'b1; step(); irq_ack = 1'b0; #1;
    chk("R4 ack", flag, 1'b0);
    tick = 1'b1; irq_ack = 1'b1; step(); tick = 1'b0; irq_ack = 1'b0; #1;
    chk("R4 set wins", flag, 1'b1);
    irq_ack = 1'b1; step(); irq_ack = 1'b0; #1;
    irq_en = 1'b0;
    cnt = 16'h0100;
  endtask

  task automatic t_timer_no_mod();
    tick = 1'b1;
    for (int i = 0; i < 20; i++) begin
      cnt = cnt + 16'd1;
      step();
    end
    tick = 1'b0; #1;
    chk("R9 stable", top_val, 16'h5566);
  endtask

  task automatic t_pwm();
    mode = 2'b10;
    bus_wr(2'b01, 8'h0A);
    bus_wr(2'b00, 8'h0B);
    chk("R7 held", top_val, 16'h5566);
    at_top = 1'b1; step(); at_top = 1'b0; #1;
    chk("R8 top no tick", top_val, 16'h5566);
    tick = 1'b1; at_bottom = 1'b1; step(); at_bottom = 1'b0; tick = 1'b0; #1;
    chk("R8 ss bottom", top_val, 16'h5566);
    tick = 1'b1; at_top = 1'b1; step(); at_top = 1'b0; tick = 1'b0; #1;
    chk("R8 ss top", top_val, 16'h0A0B);
    mode = 2'b11;
    bus_wr(2'b01, 8'h0C);
    bus_wr(2'b00, 8'h0D);
    chk("R7 ds held", top_val, 16'h0A0B);
    tick = 1'b1; at_top = 1'b1; step(); at_top = 1'b0; tick = 1'b0; #1;
    chk("R8 ds top", top_val, 16'h0A0B);
    at_bottom = 1'b1; step(); at_bottom = 1'b0; #1;
    chk("R8 ds no tick", top_val, 16'h0A0B);
    tick = 1'b1; at_bottom = 1'b1; step(); at_bottom = 1'b0; tick = 1'b0; #1;
    chk("R8 ds bottom", top_val, 16'h0C0D);
  endtask

  task automatic t_collide();
    mode = 2'b00;
    cnt = 16'h0C0D; #1;
    chk("R10 pre flag", flag, 1'b0);
    tick = 1'b1;
    bus_wr(2'b00, 8'h77);
    tick = 1'b0; #1;
    chk("R10 value", top_val, 16'h0C77);
    chk("R10 flag", flag, 1'b1);
    chk("R10 match gone", match, 1'b0);
  endtask

  initial begin
    rst_n = 1'b0; tick = 1'b0; at_top = 1'b0; at_bottom = 1'b0;
    irq_en = 1'b0; irq_ack = 1'b0; wr_en = 1'b0; wr_addr = 2'b00;
    wr_data = 8'h00; mode = 2'b00; cnt = 16'h0005;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    repeat (3) step();
    t_reset();
    t_direct();
    t_flag();
    t_timer_no_mod();
    t_pwm();
    t_collide();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #4000000;
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog act=hung exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule